// File: doc/BRIEF.md
# Bidirectional Dual-Clock Buffer with Mailbox Bypass

This block joins two agents, port A and port B, that each run on their own free-running clock. The two clocks may be unrelated, or they may be one and the same net. Inside are two independent first-in first-out queues, one for each direction. The forward queue takes words written at port A and delivers them at port B. The return queue takes words written at port B and delivers them at port A. Each queue holds 64 words of 36 bits. Next to each queue sits a one-word mailbox that lets a single urgent word overtake the queued traffic. The sender sees a busy flag while its mail is outstanding, and the receiver sees an available flag while mail is waiting for it.

Each port drives four controls: a select, an enable, a write/read direction and a mailbox choice. On a rising edge of its own clock, a port whose select and enable are both high either writes toward the far side or reads what the far side has sent. Every flag a port sees is produced in that port's own clock domain. Queue pointers cross between the domains in Gray code through two-flop synchronisers, and mailbox handshakes cross as toggles. The two threshold flags compare against one shared offset. That offset is picked at reset from four preset values by a two-bit select input.

Top module: `bidir_mbox_fifo`

## Requirements
- R1: Words written at port A (select=1, enable=1, write=1, mailbox=0) come out at port B in the order they were written, without change, and words written at port B come out at port A in the same way. Each queue holds 64 words.
- R2: A port does nothing on a clock edge unless its select and its enable are both 1. When active, write=1 sends toward the other port, write=0 takes from the other port, and mailbox=1 sends the access to the mailbox instead of the queue.
- R3: A write to a full queue is dropped and a read from an empty queue is dropped. A dropped read leaves the read-data output unchanged.
- R4: The full flag at the writing port is 1 exactly when 64 words are held, and the empty flag at the reading port is 1 exactly when none are held. Both flags are made from pointers that cross in Gray code, and both settle within four cycles of the last access at the opposite port.
- R5: The offset is latched from fs_sel while reset is active: 0 gives 16, 1 gives 12, 2 gives 8 and 3 gives 4 words. Almost-empty is 1 when the number of words held is at or below the offset. Almost-full is 1 when the free space is at or below the offset.
- R6: Read data is registered. An accepted read at one rising edge shows its word on the read-data output after that edge. The output holds its value in every cycle without an accepted read.
- R7: When a port writes and the opposite port reads the same queue on the same clock edge, both accesses take effect, and the order of the words is kept.
- R8: A mailbox write taken while the sender's busy flag is 0 stores the word and raises the sender's busy flag. The receiver's available flag rises within four cycles. A mailbox read taken while mail is available returns that word and clears the available flag, and the sender's busy flag then clears within four cycles. A mailbox write while busy is dropped. A mailbox read with no mail is dropped. Mailbox traffic never changes either queue.
- R9: Reset empties both queues and both mailboxes. After reset, both empty flags and both almost-empty flags are 1, both full flags, both almost-full flags and all mail flags are 0, and both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for the whole block |
| fs_sel | input | 2 | Threshold offset select, sampled during reset |
| a_sel | input | 1 | Port A select |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A enable |
| a_mbox | input | 1 | Port A mailbox choice |
| a_wdata | input | 36 | Port A write data |
| a_rdata | output | 36 | Port A registered read data |
| a_full | output | 1 | Forward queue full (port A clock) |
| a_afull | output | 1 | Forward queue almost full (port A clock) |
| a_empty | output | 1 | Return queue empty (port A clock) |
| a_aempty | output | 1 | Return queue almost empty (port A clock) |
| a_mail_busy | output | 1 | Mail from A not yet read by B |
| a_mail_avail | output | 1 | Mail from B waiting for A |
| b_sel | input | 1 | Port B select |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_en | input | 1 | Port B enable |
| b_mbox | input | 1 | Port B mailbox choice |
| b_wdata | input | 36 | Port B write data |
| b_rdata | output | 36 | Port B registered read data |
| b_full | output | 1 | Return queue full (port B clock) |
| b_afull | output | 1 | Return queue almost full (port B clock) |
| b_empty | output | 1 | Forward queue empty (port B clock) |
| b_aempty | output | 1 | Forward queue almost empty (port B clock) |
| b_mail_busy | output | 1 | Mail from B not yet read by A |
| b_mail_avail | output | 1 | Mail from A waiting for B |

## Verification
The bench builds the block with its default parameters: 36-bit words, 64-word queues, two-flop synchronisers and an offset base of 16 that steps down by 4. Both ports run on one shared clock, so every crossing delay is a fixed number of cycles. With a depth of 64, the bench fills and drains each direction one word at a time under each of the four offset selects. It checks every occupancy level against the full, empty and threshold flags, computed as arithmetic on the word count. It also drives the blocked access at both ends, streaming with a write and a read on the same edge, and the mailbox handshake in both directions.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

  // Decoded access a port performs on one clock edge.
  typedef enum logic [2:0] {
    OP_NONE,
    OP_FIFO_PUT,
    OP_FIFO_TAKE,
    OP_MAIL_PUT,
    OP_MAIL_TAKE
  } port_op_e;

  // Number of threshold presets selected by fs_sel.
  localparam int unsigned N_PRESETS = 4;

endpackage

// File: rtl/bmf_rst_sync.sv
module bmf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // Asserts at once, releases on the STAGES-th edge after arst_n rises.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/bmf_sync.sv
module bmf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= '0;
      end
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/bmf_fifo.sv
module bmf_fifo #(
  parameter int DW   = 36,
  parameter int AW   = 6,
  parameter int SYNC = 2
) (
  // write side
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          w_put,
  input  logic [DW-1:0] w_data,
  input  logic [AW:0]   w_off,
  output logic          w_full,
  output logic          w_afull,
  output logic [AW:0]   w_level,
  output logic [AW:0]   w_gray,
  // read side
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          r_take,
  input  logic [AW:0]   r_off,
  output logic [DW-1:0] r_head,
  output logic          r_empty,
  output logic          r_aempty
);

  localparam int          PW       = AW + 1;
  localparam int          DEPTH    = 1 << AW;
  localparam logic [AW:0] FULL_LVL = PW'(DEPTH);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin_q, wbin_d, wgray_q;
  logic [PW-1:0] rgray_w, rbin_w;
  logic          put_ok;

  bmf_sync #(.W(PW), .STAGES(SYNC)) u_r2w (
    .clk   (wclk),
    .rst_n (wrst_n),
    .d     (rgray_q),
    .q     (rgray_w)
  );

  always_comb begin
    rbin_w  = from_gray(rgray_w);
    w_level = wbin_q - rbin_w;
    w_full  = (w_level == FULL_LVL);
    w_afull = ((FULL_LVL - w_level) <= w_off);
    put_ok  = w_put && !w_full;
    wbin_d  = wbin_q + PW'(put_ok);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= to_gray(wbin_d);
    end
  end

  always_ff @(posedge wclk) begin
    if (put_ok) begin
      mem[wbin_q[AW-1:0]] <= w_data;
    end
  end

  assign w_gray = wgray_q;

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin_q, rbin_d, rgray_q;
  logic [PW-1:0] wgray_r, wbin_r, r_level;
  logic          take_ok;

  bmf_sync #(.W(PW), .STAGES(SYNC)) u_w2r (
    .clk   (rclk),
    .rst_n (rrst_n),
    .d     (wgray_q),
    .q     (wgray_r)
  );

  always_comb begin
    wbin_r   = from_gray(wgray_r);
    r_level  = wbin_r - rbin_q;
    r_empty  = (r_level == '0);
    r_aempty = (r_level <= r_off);
    take_ok  = r_take && !r_empty;
    rbin_d   = rbin_q + PW'(take_ok);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= to_gray(rbin_d);
    end
  end

  assign r_head = mem[rbin_q[AW-1:0]];

endmodule

// File: rtl/bmf_mailbox.sv
module bmf_mailbox #(
  parameter int DW   = 36,
  parameter int SYNC = 2
) (
  input  logic          s_clk,
  input  logic          s_rst_n,
  input  logic          s_put,
  input  logic [DW-1:0] s_data,
  output logic          s_busy,
  input  logic          r_clk,
  input  logic          r_rst_n,
  input  logic          r_take,
  output logic          r_avail,
  output logic [DW-1:0] r_data
);

  // sender domain
  logic          s_tog_q, s_tog_d, ack_s, put_ok;
  logic [DW-1:0] word_q;
  // receiver domain
  logic          r_tog_q, r_tog_d, req_r, take_ok;

  bmf_sync #(.W(1), .STAGES(SYNC)) u_ack (
    .clk   (s_clk),
    .rst_n (s_rst_n),
    .d     (r_tog_q),
    .q     (ack_s)
  );

  bmf_sync #(.W(1), .STAGES(SYNC)) u_req (
    .clk   (r_clk),
    .rst_n (r_rst_n),
    .d     (s_tog_q),
    .q     (req_r)
  );

  always_comb begin
    s_busy  = s_tog_q ^ ack_s;
    put_ok  = s_put && !s_busy;
    s_tog_d = s_tog_q ^ put_ok;
  end

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      s_tog_q <= 1'b0;
    end else begin
      s_tog_q <= s_tog_d;
    end
  end

  // Held stable from the write until the acknowledge returns.
  always_ff @(posedge s_clk) begin
    if (put_ok) begin
      word_q <= s_data;
    end
  end

  always_comb begin
    r_avail = req_r ^ r_tog_q;
    take_ok = r_take && r_avail;
    r_tog_d = r_tog_q ^ take_ok;
  end

  always_ff @(posedge r_clk or negedge r_rst_n) begin
    if (!r_rst_n) begin
      r_tog_q <= 1'b0;
    end else begin
      r_tog_q <= r_tog_d;
    end
  end

  assign r_data = word_q;

endmodule

// File: rtl/bmf_port.sv
module bmf_port
  import bmf_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic          en,
  input  logic          mbox,
  input  logic          tx_full,
  input  logic          tx_busy,
  input  logic          rx_empty,
  input  logic          rx_avail,
  input  logic [DW-1:0] rx_head,
  input  logic [DW-1:0] rx_mail,
  output logic          fifo_put,
  output logic          fifo_take,
  output logic          mail_put,
  output logic          mail_take,
  output logic [DW-1:0] rdata
);

  port_op_e      op;
  logic [DW-1:0] rdata_q, rdata_d;

  // R2: decode the four controls into one access kind
  always_comb begin
    op = OP_NONE;
    if (sel && en) begin
      case ({mbox, wr})
        2'b01:   op = OP_FIFO_PUT;
        2'b00:   op = OP_FIFO_TAKE;
        2'b11:   op = OP_MAIL_PUT;
        default: op = OP_MAIL_TAKE;
      endcase
    end
  end

  // R3 / R8: drop accesses the far side cannot accept
  always_comb begin
    fifo_put  = (op == OP_FIFO_PUT)  && !tx_full;
    fifo_take = (op == OP_FIFO_TAKE) && !rx_empty;
    mail_put  = (op == OP_MAIL_PUT)  && !tx_busy;
    mail_take = (op == OP_MAIL_TAKE) && rx_avail;
  end

  // R6: registered read data, loaded only by an accepted read
  always_comb begin
    rdata_d = rdata_q;
    if (fifo_take) begin
      rdata_d = rx_head;
    end else if (mail_take) begin
      rdata_d = rx_mail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/bidir_mbox_fifo.sv
module bidir_mbox_fifo #(
  parameter int DW        = 36,
  parameter int AW        = 6,
  parameter int SYNC      = 2,
  parameter int OFF_BASE  = 16,
  parameter int OFF_STEP  = 4
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic [1:0]    fs_sel,
  input  logic          a_sel,
  input  logic          a_wr,
  input  logic          a_en,
  input  logic          a_mbox,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_full,
  output logic          a_afull,
  output logic          a_empty,
  output logic          a_aempty,
  output logic          a_mail_busy,
  output logic          a_mail_avail,
  input  logic          b_sel,
  input  logic          b_wr,
  input  logic          b_en,
  input  logic          b_mbox,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_full,
  output logic          b_afull,
  output logic          b_empty,
  output logic          b_aempty,
  output logic          b_mail_busy,
  output logic          b_mail_avail
);

  localparam int PW = AW + 1;

  // ---------------- per-domain reset and offset (index 0 = A, 1 = B) ----------------
  logic [1:0]    dom_clk;
  logic [1:0]    dom_rst_n;
  logic [PW-1:0] dom_off [2];

  assign dom_clk = {clk_b, clk_a};

  for (genvar g = 0; g < 2; g++) begin : g_dom
    logic [1:0]    fs_q;
    logic [1:0]    fs_d;
    logic [PW-1:0] off_d;

    bmf_rst_sync #(.STAGES(SYNC)) u_rst (
      .clk    (dom_clk[g]),
      .arst_n (rst_n),
      .srst_n (dom_rst_n[g])
    );

    // R5: offset select captured while the local reset is active
    always_comb begin
      fs_d  = dom_rst_n[g] ? fs_q : fs_sel;
      off_d = PW'(OFF_BASE - OFF_STEP * int'(fs_q));
    end

    always_ff @(posedge dom_clk[g]) begin
      fs_q <= fs_d;
    end

    assign dom_off[g] = off_d;
  end

  logic rst_a_n, rst_b_n;
  assign rst_a_n = dom_rst_n[0];
  assign rst_b_n = dom_rst_n[1];

  // ---------------- port control ----------------
  logic          a_fifo_put, a_fifo_take, a_mail_put, a_mail_take;
  logic          b_fifo_put, b_fifo_take, b_mail_put, b_mail_take;
  logic [DW-1:0] f1_head, f2_head, mb1_data, mb2_data;
  logic [PW-1:0] f1_wlevel, f2_wlevel, f1_wgray, f2_wgray;

  bmf_port #(.DW(DW)) u_port_a (
    .clk       (clk_a),
    .rst_n     (rst_a_n),
    .sel       (a_sel),
    .wr        (a_wr),
    .en        (a_en),
    .mbox      (a_mbox),
    .tx_full   (a_full),
    .tx_busy   (a_mail_busy),
    .rx_empty  (a_empty),
    .rx_avail  (a_mail_avail),
    .rx_head   (f2_head),
    .rx_mail   (mb2_data),
    .fifo_put  (a_fifo_put),
    .fifo_take (a_fifo_take),
    .mail_put  (a_mail_put),
    .mail_take (a_mail_take),
    .rdata     (a_rdata)
  );

  bmf_port #(.DW(DW)) u_port_b (
    .clk       (clk_b),
    .rst_n     (rst_b_n),
    .sel       (b_sel),
    .wr        (b_wr),
    .en        (b_en),
    .mbox      (b_mbox),
    .tx_full   (b_full),
    .tx_busy   (b_mail_busy),
    .rx_empty  (b_empty),
    .rx_avail  (b_mail_avail),
    .rx_head   (f1_head),
    .rx_mail   (mb1_data),
    .fifo_put  (b_fifo_put),
    .fifo_take (b_fifo_take),
    .mail_put  (b_mail_put),
    .mail_take (b_mail_take),
    .rdata     (b_rdata)
  );

  // ---------------- forward queue: A writes, B reads (R1) ----------------
  bmf_fifo #(.DW(DW), .AW(AW), .SYNC(SYNC)) u_fwd (
    .wclk     (clk_a),
    .wrst_n   (rst_a_n),
    .w_put    (a_fifo_put),
    .w_data   (a_wdata),
    .w_off    (dom_off[0]),
    .w_full   (a_full),
    .w_afull  (a_afull),
    .w_level  (f1_wlevel),
    .w_gray   (f1_wgray),
    .rclk     (clk_b),
    .rrst_n   (rst_b_n),
    .r_take   (b_fifo_take),
    .r_off    (dom_off[1]),
    .r_head   (f1_head),
    .r_empty  (b_empty),
    .r_aempty (b_aempty)
  );

  // ---------------- return queue: B writes, A reads (R1) ----------------
  bmf_fifo #(.DW(DW), .AW(AW), .SYNC(SYNC)) u_ret (
    .wclk     (clk_b),
    .wrst_n   (rst_b_n),
    .w_put    (b_fifo_put),
    .w_data   (b_wdata),
    .w_off    (dom_off[1]),
    .w_full   (b_full),
    .w_afull  (b_afull),
    .w_level  (f2_wlevel),
    .w_gray   (f2_wgray),
    .rclk     (clk_a),
    .rrst_n   (rst_a_n),
    .r_take   (a_fifo_take),
    .r_off    (dom_off[0]),
    .r_head   (f2_head),
    .r_empty  (a_empty),
    .r_aempty (a_aempty)
  );

  // ---------------- mailboxes (R8) ----------------
  bmf_mailbox #(.DW(DW), .SYNC(SYNC)) u_mb_fwd (
    .s_clk   (clk_a),
    .s_rst_n (rst_a_n),
    .s_put   (a_mail_put),
    .s_data  (a_wdata),
    .s_busy  (a_mail_busy),
    .r_clk   (clk_b),
    .r_rst_n (rst_b_n),
    .r_take  (b_mail_take),
    .r_avail (b_mail_avail),
    .r_data  (mb1_data)
  );

  bmf_mailbox #(.DW(DW), .SYNC(SYNC)) u_mb_ret (
    .s_clk   (clk_b),
    .s_rst_n (rst_b_n),
    .s_put   (b_mail_put),
    .s_data  (b_wdata),
    .s_busy  (b_mail_busy),
    .r_clk   (clk_a),
    .r_rst_n (rst_a_n),
    .r_take  (a_mail_take),
    .r_avail (a_mail_avail),
    .r_data  (mb2_data)
  );

endmodule

// File: rtl/bmf_checker.sv
module bmf_checker #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_n,
  input logic          a_sel,
  input logic          a_wr,
  input logic          a_en,
  input logic          a_mbox,
  input logic          a_full,
  input logic          a_afull,
  input logic          a_empty,
  input logic          a_aempty,
  input logic          a_mail_busy,
  input logic [DW-1:0] a_rdata,
  input logic          b_sel,
  input logic          b_wr,
  input logic          b_en,
  input logic          b_mbox,
  input logic          b_full,
  input logic          b_afull,
  input logic          b_empty,
  input logic          b_aempty,
  input logic          b_mail_busy,
  input logic [DW-1:0] b_rdata,
  input logic [AW:0]   f1_wlevel,
  input logic [AW:0]   f2_wlevel,
  input logic [AW:0]   f1_wgray,
  input logic [AW:0]   f2_wgray
);

  localparam logic [AW:0] FULL_LVL = (AW + 1)'(1 << AW);

  // R3: the write side never counts more words than the queue holds
  p_no_overflow_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
    f1_wlevel <= FULL_LVL);
  p_no_overflow_ret_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
    f2_wlevel <= FULL_LVL);

  // R4: a crossing pointer moves by at most one Gray bit per edge
  p_gray_step_r4: assert property (@(posedge clk_a) disable iff (!rst_n)
    $countones(f1_wgray ^ $past(f1_wgray)) <= 1);
  p_gray_step_ret_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
    $countones(f2_wgray ^ $past(f2_wgray)) <= 1);

  // R5: the threshold flags cover their hard counterparts
  p_full_afull_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_full |-> a_afull);
  p_empty_aempty_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_empty |-> b_aempty);
  p_empty_aempty_a_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_empty |-> a_aempty);
  p_full_afull_b_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_full |-> b_afull);

  // R6: read data moves only after a read request
  p_rdata_hold_b_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
    !(b_sel && b_en && !b_wr) |=> $stable(b_rdata));
  p_rdata_hold_a_r6: assert property (@(posedge clk_a) disable iff (!rst_n)
    !(a_sel && a_en && !a_wr) |=> $stable(a_rdata));

  // R8: an accepted mailbox write marks the sender busy
  p_mail_busy_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_sel && a_en && a_wr && a_mbox && !a_mail_busy) |=> a_mail_busy);
  p_mail_busy_b_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_sel && b_en && b_wr && b_mbox && !b_mail_busy) |=> b_mail_busy);

endmodule

bind bidir_mbox_fifo bmf_checker #(.DW(DW), .AW(AW)) chk_i (.*);

// File: tb/bidir_mbox_fifo_tb.sv
module bidir_mbox_fifo_tb_top;

  localparam int DW    = 36;
  localparam int DEPTH = 64;
  localparam int WD    = 100000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          clk_a, clk_b, rst_n;
  logic [1:0]    fs_sel;
  logic          a_sel, a_wr, a_en, a_mbox, b_sel, b_wr, b_en, b_mbox;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic          a_full, a_afull, a_empty, a_aempty, a_mail_busy, a_mail_avail;
  logic          b_full, b_afull, b_empty, b_aempty, b_mail_busy, b_mail_avail;

  assign clk_a = clk;
  assign clk_b = clk;

  bidir_mbox_fifo dut_i (.*);

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_port(int side, bit s, bit w, bit e, bit m, logic [DW-1:0] d);
    if (side == 0) begin
      a_sel = s; a_wr = w; a_en = e; a_mbox = m; a_wdata = d;
    end else begin
      b_sel = s; b_wr = w; b_en = e; b_mbox = m; b_wdata = d;
    end
  endtask

  task automatic idle_all();
    set_port(0, 0, 0, 0, 0, '0);
    set_port(1, 0, 0, 0, 0, '0);
  endtask

  // One access at the next rising edge; returns at the following falling edge.
  task automatic op(int side, bit w, bit m, logic [DW-1:0] d);
    set_port(side, 1, w, 1, m, d);
    tick();
    set_port(side, 0, 0, 0, 0, '0);
  endtask

  task automatic do_reset(int f);
    idle_all();
    fs_sel = 2'(f);
    rst_n  = 1'b0;
    repeat (3) tick();
    rst_n  = 1'b1;
    repeat (4) tick();
  endtask

  function automatic logic [DW-1:0] pat(int d, int f, int i);
    return {4'(d * 4 + f), 8'(i), 24'(i * 40503 + 17)};
  endfunction

  // d = 0: forward queue (A writes, B reads); d = 1: return queue.
  function automatic logic wr_full(int d);  return d == 0 ? a_full  : b_full;  endfunction
  function automatic logic wr_afull(int d); return d == 0 ? a_afull : b_afull; endfunction
  function automatic logic rd_empty(int d); return d == 0 ? b_empty : a_empty; endfunction
  function automatic logic rd_aempty(int d); return d == 0 ? b_aempty : a_aempty; endfunction
  function automatic logic [DW-1:0] rd_data(int d); return d == 0 ? b_rdata : a_rdata; endfunction

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    idle_all();
    fs_sel = 2'd0;
    rst_n  = 1'b0;
    repeat (3) tick();

    // Sweep both directions under all four offset presets.
    for (int d = 0; d < 2; d++) begin
      for (int f = 0; f < 4; f++) begin
        int off;
        int wside;
        int rside;
        off   = 16 - 4 * f;
        wside = d;
        rside = 1 - d;
        do_reset(f);
        // R9 reset state
        chk("R9 empty after reset", 64'(rd_empty(d)), 64'd1);
        chk("R9 aempty after reset", 64'(rd_aempty(d)), 64'd1);
        chk("R9 full after reset", 64'(wr_full(d)), 64'd0);
        chk("R9 afull after reset", 64'(wr_afull(d)), 64'd0);
        chk("R9 rdata after reset", 64'(rd_data(d)), 64'd0);
        chk("R9 mail flags after reset",
            64'({a_mail_busy, a_mail_avail, b_mail_busy, b_mail_avail}), 64'd0);

        // Fill one word at a time (R1, R4, R5).
        for (int i = 1; i <= DEPTH; i++) begin
          op(wside, 1, 0, pat(d, f, i - 1));
          repeat (4) tick();
          chk("R4 full while filling", 64'(wr_full(d)), 64'(i == DEPTH));
          chk("R4 empty while filling", 64'(rd_empty(d)), 64'd0);
          chk("R5 afull while filling", 64'(wr_afull(d)), 64'((DEPTH - i) <= off));
          chk("R5 aempty while filling", 64'(rd_aempty(d)), 64'(i <= off));
        end

        // R3 write into a full queue is dropped.
        op(wside, 1, 0, pat(d, f, 200));
        repeat (4) tick();
        chk("R3 full stays after extra write", 64'(wr_full(d)), 64'd1);

        // Drain (R1, R4, R5, R6).
        for (int i = 0; i < DEPTH; i++) begin
          int held;
          op(rside, 0, 0, '0);
          chk("R1 R6 read order and data", 64'(rd_data(d)), 64'(pat(d, f, i)));
          repeat (4) tick();
          held = DEPTH - 1 - i;
          chk("R4 empty while draining", 64'(rd_empty(d)), 64'(held == 0));
          chk("R4 full while draining", 64'(wr_full(d)), 64'd0);
          chk("R5 aempty while draining", 64'(rd_aempty(d)), 64'(held <= off));
          chk("R5 afull while draining", 64'(wr_afull(d)), 64'((DEPTH - held) <= off));
        end

        // R3 read from an empty queue is dropped; data holds.
        op(rside, 0, 0, '0);
        chk("R3 rdata holds on empty read", 64'(rd_data(d)), 64'(pat(d, f, DEPTH - 1)));
        repeat (4) tick();
        chk("R3 still empty", 64'(rd_empty(d)), 64'd1);
      end
    end

    // R2: accesses without select or without enable do nothing.
    do_reset(0);
    set_port(0, 0, 1, 1, 0, pat(0, 0, 1));
    tick();
    set_port(0, 1, 1, 0, 0, pat(0, 0, 2));
    tick();
    set_port(0, 0, 1, 1, 1, pat(0, 0, 3));
    tick();
    idle_all();
    repeat (4) tick();
    chk("R2 no write without sel/en", 64'(b_empty), 64'd1);
    chk("R2 no mail without sel", 64'(b_mail_avail), 64'd0);
    op(0, 1, 0, pat(0, 0, 4));
    repeat (4) tick();
    set_port(1, 1, 0, 0, 0, '0);
    tick();
    set_port(1, 0, 0, 1, 0, '0);
    tick();
    idle_all();
    chk("R2 no read without sel/en", 64'(b_rdata), 64'd0);
    chk("R2 word still held", 64'(b_empty), 64'd0);
    op(1, 0, 1, '0);
    chk("R8 mailbox read leaves queue alone", 64'(b_rdata), 64'd0);
    op(1, 0, 0, '0);
    chk("R2 enabled read returns word", 64'(b_rdata), 64'(pat(0, 0, 4)));

    // R7: write and read on the same edge, streamed.
    do_reset(0);
    for (int i = 0; i < 8; i++) op(0, 1, 0, pat(0, 0, i));
    repeat (4) tick();
    for (int k = 0; k < 40; k++) begin
      set_port(0, 1, 1, 1, 0, pat(0, 0, 8 + k));
      set_port(1, 1, 0, 1, 0, '0);
      tick();
      chk("R7 same-edge read data", 64'(b_rdata), 64'(pat(0, 0, k)));
    end
    idle_all();
    repeat (4) tick();
    chk("R7 level kept after streaming", 64'({b_empty, b_aempty, a_afull}), 64'b010);
    for (int k = 0; k < 8; k++) begin
      op(1, 0, 0, '0);
      chk("R7 tail order", 64'(b_rdata), 64'(pat(0, 0, 40 + k)));
    end
    repeat (4) tick();
    chk("R7 empty after tail", 64'(b_empty), 64'd1);

    // R8: mailbox A to B.
    do_reset(0);
    op(0, 1, 1, 36'h5_1234_5678);
    chk("R8 sender busy at once", 64'(a_mail_busy), 64'd1);
    repeat (4) tick();
    chk("R8 receiver sees mail", 64'(b_mail_avail), 64'd1);
    chk("R8 queue untouched by mail", 64'(b_empty), 64'd1);
    op(0, 1, 1, 36'h0_0000_0BAD);
    op(1, 0, 1, '0);
    chk("R8 mail data", 64'(b_rdata), 64'h5_1234_5678);
    chk("R8 avail clears on read", 64'(b_mail_avail), 64'd0);
    repeat (4) tick();
    chk("R8 busy clears after read", 64'(a_mail_busy), 64'd0);
    op(1, 0, 1, '0);
    chk("R8 read with no mail holds", 64'(b_rdata), 64'h5_1234_5678);
    op(0, 1, 1, 36'h9_8765_4321);
    repeat (4) tick();
    op(1, 0, 1, '0);
    chk("R8 second mail", 64'(b_rdata), 64'h9_8765_4321);

    // R8: mailbox B to A.
    op(1, 1, 1, 36'hA_CAFE_0001);
    repeat (4) tick();
    chk("R8 reverse flags", 64'({b_mail_busy, a_mail_avail}), 64'b11);
    op(0, 0, 1, '0);
    chk("R8 reverse data", 64'(a_rdata), 64'hA_CAFE_0001);
    repeat (4) tick();
    chk("R8 reverse flags clear", 64'({b_mail_busy, a_mail_avail}), 64'b00);

    // R9: reset drops pending mail and queued words.
    op(0, 1, 1, 36'h1_1111_1111);
    op(1, 1, 0, 36'h2_2222_2222);
    repeat (4) tick();
    do_reset(0);
    chk("R9 mail cleared by reset",
        64'({a_mail_busy, a_mail_avail, b_mail_busy, b_mail_avail}), 64'd0);
    chk("R9 return queue cleared by reset", 64'({a_empty, a_aempty, b_full, b_afull}), 64'b1100);

    summary();
    $finish;
  end

endmodule